// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches six BCD time and calendar counters: seconds, minutes, hours, weekday, day of month and month. It holds one alarm slot for each of them. A slot has an arm bit and a BCD target value. Software writes and reads the slots over a simple register port. The unit decides, on every clock, whether every armed slot equals its live counter. When that decision changes from false to true, a sticky alarm flag is raised. The flag stays high until software clears it.

The counters themselves are supplied from outside, and so is any routing of the flag to an interrupt controller. A slot whose arm bit is low is left out of the comparison, whatever target value it holds. A set of slots with no arm bit high never raises an alarm. The only reset input clears the arm bits and the flag. Target values are never reset, so a previously written time survives a reset and only has to be re-armed.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: Slot select codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month. In each 8-bit slot word, bit 7 is the arm bit and the BCD target sits in the low bits. The target widths are 7 bits for seconds, 7 for minutes, 6 for hours, 3 for weekday, 6 for day and 5 for month. Reading a slot returns the arm bit and target last written.
- R2: Write data bits between the target width and bit 7 are discarded and read back as zero. Select codes 6 and 7 accept no write and read as 0x00.
- R3: A slot whose arm bit is 0 has no influence on the alarm, whatever its target and counter hold.
- R4: An alarm needs every armed slot's full target (both BCD digits) to equal its counter. A difference in the tens digit alone prevents it.
- R5: While no slot is armed, the alarm flag never rises.
- R6: The flag is set at the first clock edge at which the overall match condition is true after having been false. A counter change that creates a match shows up on the flag one cycle later.
- R7: Once set, the flag holds until the clear input is high at an edge. A match that stays true after a clear does not set the flag again.
- R8: If a new match rise and a clear land on the same edge, the flag ends up set.
- R9: Reset clears every arm bit and the flag, and leaves every target value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (arm bits and flag only) |
| wr_en | input | 1 | Write strobe for the slot named by wr_sel |
| wr_sel | input | 3 | Slot select for writes |
| wr_data | input | 8 | Slot write word: arm bit 7, BCD target below |
| rd_sel | input | 3 | Slot select for readback |
| rd_data | output | 8 | Readback word of the selected slot |
| cnt_sec | input | 7 | Live seconds counter, BCD |
| cnt_min | input | 7 | Live minutes counter, BCD |
| cnt_hour | input | 6 | Live hours counter, BCD |
| cnt_wday | input | 3 | Live weekday counter |
| cnt_day | input | 6 | Live day-of-month counter, BCD |
| cnt_mon | input | 5 | Live month counter, BCD |
| clr_flag | input | 1 | Clears the alarm flag at the edge |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The match logic is driven with counters that all equal their targets while nothing is armed. This separates a design that honours the arm bits from one that compares every slot. A single armed seconds slot is then stepped into and out of a match while a disarmed minutes slot holds a different value. This shows the rising-edge behaviour, the one-cycle latency and the re-arm after a mismatch. A second armed slot, and then a month whose counter differs only in the tens digit, separate a full-width AND of all armed slots from a partial or single-digit compare. A match rise placed on the same edge as a clear, followed by a reset with the targets read back, settles priority and the scope of the reset.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int DATA_W     = 8;
    localparam int SEL_W      = 3;
    localparam int ARM_BIT    = DATA_W - 1;
    localparam int VAL_MAX_W  = DATA_W - 1;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_DAY  = 3'd4,
        FLD_MON  = 3'd5
    } field_e;

    // Target width of each slot, indexed by its select code.
    function automatic int field_width(int idx);
        case (idx)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return HOUR_W;
            3:       return WDAY_W;
            4:       return DAY_W;
            default: return MON_W;
        endcase
    endfunction

    // Decoded write request shared with every slot.
    typedef struct packed {
        logic                 arm;
        logic [VAL_MAX_W-1:0] val;
    } slot_word_t;

endpackage

// File: rtl/rtc_alarm_slot.sv
module rtc_alarm_slot
    import rtc_alarm_pkg::*;
#(
    parameter int W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic              wr_arm,
    input  logic [W-1:0]      wr_val,
    input  logic [W-1:0]      cnt,
    output logic              armed,
    output logic              equal,
    output logic [DATA_W-1:0] rd_word
);

    logic         arm_q;
    logic [W-1:0] val_q;

    // Arm bit is the only resettable state in a slot.
    always_ff @(posedge clk) begin
        if (rst)
            arm_q <= 1'b0;
        else if (wr_hit)
            arm_q <= wr_arm;
    end

    // Target value keeps its contents across reset.
    always_ff @(posedge clk) begin
        if (wr_hit)
            val_q <= wr_val;
    end

    assign armed = arm_q;
    assign equal = (val_q == cnt);

    always_comb begin
        rd_word          = '0;
        rd_word[ARM_BIT] = arm_q;
        rd_word[W-1:0]   = val_q;
    end

endmodule

// File: rtl/rtc_alarm_reduce.sv
module rtc_alarm_reduce #(
    parameter int N = 6
) (
    input  logic [N-1:0] armed_vec,
    input  logic [N-1:0] equal_vec,
    output logic         match_all
);

    logic any_armed;
    logic all_ok;

    assign any_armed = |armed_vec;
    // A disarmed slot counts as satisfied; an armed one must be equal.
    assign all_ok    = &(equal_vec | ~armed_vec);
    assign match_all = any_armed & all_ok;

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic match_in,
    input  logic clr,
    output logic match_rise,
    output logic flag
);

    logic match_q;

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= 1'b0;
        else
            match_q <= match_in;
    end

    assign match_rise = match_in & ~match_q;

    // Setting has priority over clearing on the same edge.
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (match_rise)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SEC_W-1:0]  cnt_sec,
    input  logic [MIN_W-1:0]  cnt_min,
    input  logic [HOUR_W-1:0] cnt_hour,
    input  logic [WDAY_W-1:0] cnt_wday,
    input  logic [DAY_W-1:0]  cnt_day,
    input  logic [MON_W-1:0]  cnt_mon,
    input  logic              clr_flag,
    output logic              alarm_flag
);

    slot_word_t              wr_word;
    logic [NUM_FIELDS-1:0]   armed_vec;
    logic [NUM_FIELDS-1:0]   equal_vec;
    logic [DATA_W-1:0]       rd_arr [NUM_FIELDS];
    logic                    match_all;
    logic                    match_rise;

    assign wr_word = slot_word_t'(wr_data);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
        localparam int W = field_width(g);
        logic [W-1:0] cnt_g;
        logic         hit_g;

        if (g == int'(FLD_SEC))       begin : g_c assign cnt_g = cnt_sec;  end
        else if (g == int'(FLD_MIN))  begin : g_c assign cnt_g = cnt_min;  end
        else if (g == int'(FLD_HOUR)) begin : g_c assign cnt_g = cnt_hour; end
        else if (g == int'(FLD_WDAY)) begin : g_c assign cnt_g = cnt_wday; end
        else if (g == int'(FLD_DAY))  begin : g_c assign cnt_g = cnt_day;  end
        else                          begin : g_c assign cnt_g = cnt_mon;  end

        assign hit_g = wr_en && (wr_sel == SEL_W'(g));

        rtc_alarm_slot #(.W(W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit_g),
            .wr_arm  (wr_word.arm),
            .wr_val  (wr_word.val[W-1:0]),
            .cnt     (cnt_g),
            .armed   (armed_vec[g]),
            .equal   (equal_vec[g]),
            .rd_word (rd_arr[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd_sel == SEL_W'(i))
                rd_data = rd_arr[i];
        end
    end

    rtc_alarm_reduce #(.N(NUM_FIELDS)) u_reduce (
        .armed_vec (armed_vec),
        .equal_vec (equal_vec),
        .match_all (match_all)
    );

    rtc_alarm_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .match_in   (match_all),
        .clr        (clr_flag),
        .match_rise (match_rise),
        .flag       (alarm_flag)
    );

endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk
    import rtc_alarm_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  clr_flag,
    input logic                  alarm_flag,
    input logic [NUM_FIELDS-1:0] armed_vec,
    input logic                  match_rise
);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (armed_vec == '0 && !alarm_flag));

    assert_no_arm_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (armed_vec == '0 && !alarm_flag) |=> !alarm_flag);

    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (rst)
        match_rise |=> alarm_flag);

    assert_set_only_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && !match_rise) |=> !alarm_flag);

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_flag) |=> alarm_flag);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !match_rise) |=> !alarm_flag);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && match_rise) |=> alarm_flag);

endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_flag   (clr_flag),
    .alarm_flag (alarm_flag),
    .armed_vec  (armed_vec),
    .match_rise (match_rise)
);

// File: tb/test_rtc_alarm_cmp.sv
module test_rtc_alarm_cmp;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [6:0] cnt_sec = '0;
    logic [6:0] cnt_min = '0;
    logic [5:0] cnt_hour = '0;
    logic [2:0] cnt_wday = '0;
    logic [5:0] cnt_day = '0;
    logic [4:0] cnt_mon = '0;
    logic       clr_flag = 1'b0;
    logic       alarm_flag;

    always #4 clk = ~clk;   // 125 MHz

    rtc_alarm_cmp i_rtc_alarm_cmp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cnt_sec(cnt_sec), .cnt_min(cnt_min),
        .cnt_hour(cnt_hour), .cnt_wday(cnt_wday), .cnt_day(cnt_day),
        .cnt_mon(cnt_mon), .clr_flag(clr_flag), .alarm_flag(alarm_flag)
    );

    typedef struct {
        int         kind;   // 0: alarm flag, 1: readback word
        logic [7:0] exp;
        logic [7:0] mask;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // Monitor: one expected item consumed per falling edge.
    always @(negedge clk) begin
        item_t      it;
        logic [7:0] act;
        if (q.size() > 0) begin
            it  = q.pop_front();
            act = (it.kind == 0) ? {7'b0, alarm_flag} : rd_data;
            checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_sel  = s;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic clr_pulse();
        clr_flag = 1'b1;
        tick();
        clr_flag = 1'b0;
    endtask

    task automatic expf(input logic e, input string r);
        item_t it;
        it.kind = 0; it.exp = {7'b0, e}; it.mask = 8'h01; it.req = r;
        q.push_back(it);
        tick();
    endtask

    task automatic exprd(input logic [2:0] s, input logic [7:0] e,
                         input logic [7:0] m, input string r);
        item_t it;
        rd_sel = s;
        it.kind = 1; it.exp = e; it.mask = m; it.req = r;
        q.push_back(it);
        tick();
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        // R9: reset state
        expf(1'b0, "R9 flag after reset");
        exprd(3'd0, 8'h00, 8'h80, "R9 arm bit after reset");

        // R1 / R2: layout and readback
        wr(3'd0, 8'h45);
        exprd(3'd0, 8'h45, 8'hFF, "R1 seconds readback");
        wr(3'd5, 8'h92);
        exprd(3'd5, 8'h92, 8'hFF, "R1 month readback");
        wr(3'd2, 8'h7F);
        exprd(3'd2, 8'h3F, 8'hFF, "R2 hour upper bit dropped");
        wr(3'd3, 8'hFF);
        exprd(3'd3, 8'h87, 8'hFF, "R2 weekday upper bits dropped");
        wr(3'd6, 8'hFF);
        exprd(3'd6, 8'h00, 8'hFF, "R2 unmapped select");

        // R5: all targets equal counters, nothing armed
        for (int s = 0; s < 6; s++) wr(3'(s), 8'h00);
        expf(1'b0, "R5 nothing armed");
        cnt_sec = 7'h01;
        expf(1'b0, "R5 nothing armed");
        cnt_sec = 7'h00;
        expf(1'b0, "R5 nothing armed");
        expf(1'b0, "R5 nothing armed");

        // R3 / R6: seconds armed, minutes disarmed with other value
        wr(3'd1, 8'h12);
        wr(3'd0, 8'hB0);
        expf(1'b0, "R6 no match yet");
        cnt_sec = 7'h30;
        expf(1'b0, "R6 one cycle latency");
        expf(1'b1, "R6 flag set");
        expf(1'b1, "R3 disarmed minutes ignored");

        // R7: hold, clear, no refire while match held
        expf(1'b1, "R7 hold");
        clr_pulse();
        expf(1'b0, "R7 cleared");
        expf(1'b0, "R7 no refire");

        // R6: re-arm after mismatch
        cnt_sec = 7'h31;
        expf(1'b0, "R6 mismatch");
        cnt_sec = 7'h30;
        expf(1'b0, "R6 latency again");
        expf(1'b1, "R6 re-armed");

        // R4: two armed slots
        wr(3'd1, 8'h95);
        clr_pulse();
        expf(1'b0, "R4 minutes differ");
        cnt_min = 7'h15;
        expf(1'b0, "R4 latency");
        expf(1'b1, "R4 both match");

        // R4: month tens digit only differs
        wr(3'd5, 8'h92);
        cnt_mon = 5'h02;
        clr_pulse();
        expf(1'b0, "R4 tens digit differs");
        expf(1'b0, "R4 tens digit differs");
        cnt_mon = 5'h12;
        expf(1'b0, "R4 latency");
        expf(1'b1, "R4 full match");

        // R8: rise and clear on the same edge
        cnt_mon = 5'h02;
        tick();
        cnt_mon  = 5'h12;
        clr_flag = 1'b1;
        tick();
        clr_flag = 1'b0;
        expf(1'b1, "R8 set beats clear");
        clr_pulse();
        expf(1'b0, "R7 plain clear");

        // R9: reset keeps targets, clears arm and flag
        cnt_mon = 5'h02;
        tick();
        cnt_mon = 5'h12;
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        expf(1'b0, "R9 flag cleared");
        exprd(3'd0, 8'h30, 8'hFF, "R9 seconds target kept");
        exprd(3'd1, 8'h15, 8'hFF, "R9 minutes target kept");
        exprd(3'd5, 8'h12, 8'hFF, "R9 month target kept");
        expf(1'b0, "R5 disarmed after reset");
        expf(1'b0, "R5 disarmed after reset");

        tick();
        tick();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule